// File: doc/BRIEF.md
# Instruction Prefetch Queue with Deferred Bus Fault

This block sits between an instruction bus interface and the execution side of a core. It sends fetch requests for sequential instruction words ahead of demand and holds each returned word in a small in-order queue, together with a one-bit error tag that reports whether the bus fetch of that word failed. A failed fetch does not cause an exception when it happens. The tag travels with the word. A fault is signalled only when the execution side actually takes that word from the queue.

A redirect, such as a taken branch or a task switch, is given on `flush_i` together with a new fetch address. The redirect empties the queue and cancels every pending error tag without any trace. Fetch responses that are still in flight from before the redirect are counted and discarded as they arrive. The fetch port uses a request/ready handshake, and responses come back in request order with no back-pressure. The consume port uses valid/ready.

Top module: `pfq_top`

## Requirements
- R1: After reset, `out_valid_o` and `fault_o` are low and the first fetch request presents address `RESET_ADDR` (default 0).
- R2: Request addresses start at the reset or flush address and each accepted request advances the address by `WORD_BYTES` (default 4).
- R3: A request is issued only while queued words plus live outstanding requests are fewer than `DEPTH` (default 4), and total outstanding requests (live plus discarded) never exceed `MAX_OUT` (default 8). When the consumer stalls, fetching stops with the queue full.
- R4: Consumed words come out in fetch order. Each word carries the data returned for it and its fetch address on `out_addr_o`.
- R5: A response with `rsp_err_i` high is stored with `out_err_o` high for that word. No fault is raised at fetch time or while the word waits in the queue.
- R6: `fault_o` is high in exactly the cycles where a word with its error tag set is accepted (`out_valid_o && out_ready_i`, no flush), and `fault_addr_o` then equals that word's fetch address.
- R7: In the cycle after `flush_i`, `out_valid_o` is low.
- R8: Responses to requests issued before a flush never reach the consume port.
- R9: When `flush_i` coincides with a consume handshake, the flush wins: the word is discarded and no fault is raised.
- R10: In the cycle after a flush (with no new flush), `req_valid_o` is high with the flush address whenever fewer than `MAX_OUT` requests are outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Redirect: empty the queue and restart fetch |
| flush_addr_i | input | 32 | New fetch address for the redirect |
| req_valid_o | output | 1 | Fetch request valid |
| req_ready_i | input | 1 | Bus accepts the request |
| req_addr_o | output | 32 | Fetch request address |
| rsp_valid_i | input | 1 | Fetch response valid (in request order) |
| rsp_data_i | input | 32 | Fetched instruction word |
| rsp_err_i | input | 1 | Bus error on this fetch |
| out_valid_o | output | 1 | Queue head is available |
| out_ready_i | input | 1 | Execution side takes the head word |
| out_data_o | output | 32 | Head word data |
| out_addr_o | output | 32 | Head word fetch address |
| out_err_o | output | 1 | Head word carries a bus-error tag |
| fault_o | output | 1 | An errored word is consumed this cycle |
| fault_addr_o | output | 32 | Address of the faulting word |

## Verification
The hardest situation to reach is a redirect that arrives while responses from the old stream are still in flight, especially several redirects in close succession, because stale responses must be dropped in exactly the right number. The bench keeps requests outstanding by answering the bus randomly and late, then fires redirects at a low random rate, including back-to-back redirects. Any stale word that leaked through would break the bench's expected address sequence. A directed sequence parks an errored word at the queue head behind a stalled consumer and then redirects it away in the same cycle as a consume.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;

  typedef struct packed {
    logic              err;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } pfq_entry_t;
endpackage

// File: rtl/pfq_fifo.sv
module pfq_fifo
  import pfq_pkg::*;
#(
  parameter  int unsigned DEPTH = 4,
  localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          push_i,
  input  pfq_entry_t    push_entry_i,
  input  logic          pop_i,
  output pfq_entry_t    head_o,
  output logic          valid_o,
  output logic [CW-1:0] count_o
);
  pfq_entry_t    mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !clear_i) mem[wr_q] <= push_entry_i;
  end

  assign head_o  = mem[rd_q];
  assign valid_o = (cnt_q != '0);
  assign count_o = cnt_q;

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clear_i) |-> (cnt_q < CW'(DEPTH)) || pop_i);
  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !clear_i) |-> (cnt_q != '0));
endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch
  import pfq_pkg::*;
#(
  parameter  int unsigned     DEPTH      = 4,
  parameter  int unsigned     MAX_OUT    = 8,
  parameter  int unsigned     WORD_BYTES = 4,
  parameter  logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int unsigned     CW         = $clog2(DEPTH + 1),
  localparam int unsigned     OW         = $clog2(MAX_OUT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  input  logic [CW-1:0]     occ_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              rsp_valid_i,
  output logic              rsp_live_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic [OW-1:0]     pend_o
);
  logic [ADDR_W-1:0] fetch_addr_q, rsp_addr_q;
  logic [OW-1:0]     pend_q, drop_q;  // live / discarded outstanding
  logic              fire, stale, live_raw;

  assign stale    = rsp_valid_i && (drop_q != '0);
  assign live_raw = rsp_valid_i && (drop_q == '0);

  assign req_valid_o = !flush_i
                    && ((32'(occ_i) + 32'(pend_q)) < DEPTH)
                    && ((32'(pend_q) + 32'(drop_q)) < MAX_OUT);
  assign fire       = req_valid_o && req_ready_i;
  assign rsp_live_o = live_raw && !flush_i;
  assign req_addr_o = fetch_addr_q;
  assign rsp_addr_o = rsp_addr_q;
  assign pend_o     = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_addr_q <= RESET_ADDR;
      rsp_addr_q   <= RESET_ADDR;
      pend_q       <= '0;
      drop_q       <= '0;
    end else if (flush_i) begin
      fetch_addr_q <= flush_addr_i;
      rsp_addr_q   <= flush_addr_i;
      pend_q       <= '0;
      drop_q       <= drop_q + pend_q - OW'(stale) - OW'(live_raw);
    end else begin
      if (fire)     fetch_addr_q <= fetch_addr_q + ADDR_W'(WORD_BYTES);
      if (live_raw) rsp_addr_q   <= rsp_addr_q + ADDR_W'(WORD_BYTES);
      pend_q <= pend_q + OW'(fire) - OW'(live_raw);
      drop_q <= drop_q - OW'(stale);
    end
  end

  assert_out_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(pend_q) + 32'(drop_q)) <= MAX_OUT);
  assert_rsp_expected_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |-> (pend_q != '0) || (drop_q != '0));
  assert_flush_redirect_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (req_addr_o == $past(flush_addr_i)));
endmodule

// File: rtl/pfq_top.sv
module pfq_top
  import pfq_pkg::*;
#(
  parameter  int unsigned       DEPTH      = 4,
  parameter  int unsigned       MAX_OUT    = 8,
  parameter  int unsigned       WORD_BYTES = 4,
  parameter  logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int unsigned       CW         = $clog2(DEPTH + 1),
  localparam int unsigned       OW         = $clog2(MAX_OUT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  input  logic              rsp_err_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic              out_err_o,
  output logic              fault_o,
  output logic [ADDR_W-1:0] fault_addr_o
);
  logic              rsp_live, pop;
  logic [ADDR_W-1:0] rsp_addr;
  logic [CW-1:0]     occ;
  logic [OW-1:0]     pend;
  pfq_entry_t        in_entry, head;

  pfq_fetch #(
    .DEPTH(DEPTH), .MAX_OUT(MAX_OUT), .WORD_BYTES(WORD_BYTES), .RESET_ADDR(RESET_ADDR)
  ) u_fetch (
    .clk_i, .rst_ni, .flush_i, .flush_addr_i,
    .occ_i(occ), .req_valid_o, .req_ready_i, .req_addr_o,
    .rsp_valid_i, .rsp_live_o(rsp_live), .rsp_addr_o(rsp_addr), .pend_o(pend)
  );

  assign in_entry = '{err: rsp_err_i, addr: rsp_addr, data: rsp_data_i};

  pfq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .clear_i(flush_i), .push_i(rsp_live), .push_entry_i(in_entry),
    .pop_i(pop), .head_o(head), .valid_o(out_valid_o), .count_o(occ)
  );

  // flush voids a coincident consume
  assign pop          = out_valid_o && out_ready_i && !flush_i;
  assign out_data_o   = head.data;
  assign out_addr_o   = head.addr;
  assign out_err_o    = head.err;
  assign fault_o      = pop && head.err;
  assign fault_addr_o = head.addr;

  assert_flush_empties_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !out_valid_o);
  assert_slot_reserve_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(occ) + 32'(pend)) <= DEPTH);
  assert_fault_on_take_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> out_valid_o && out_err_o && (fault_addr_o == out_addr_o));
endmodule

// File: tb/pfq_top_bench.sv
module pfq_top_bench;
  localparam int MAX_OUT = 8;
  logic        clk_i = 0, rst_ni = 0;
  logic        flush_i = 0, req_ready_i = 0, rsp_valid_i = 0, rsp_err_i = 0, out_ready_i = 0;
  logic [31:0] flush_addr_i = 0, rsp_data_i = 0;
  logic        req_valid_o, out_valid_o, out_err_o, fault_o;
  logic [31:0] req_addr_o, out_data_o, out_addr_o, fault_addr_o;

  pfq_top u_pfq_top (.*);

  always #10 clk_i = ~clk_i;  // 50 MHz

  int          checks = 0, errors = 0, faults_seen = 0;
  logic [31:0] bq [16];
  int          head = 0, tail = 0;
  logic [31:0] exp_addr = 0, exp_req = 0;
  logic        last_flush = 0;

  function automatic logic [31:0] dfn(input logic [31:0] a);
    return (a * 3) ^ 32'h5a5a_0000;
  endfunction
  function automatic logic efn(input logic [31:0] a);
    return ((a >> 2) % 7) == 3;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic fl, input logic [31:0] fa, input logic rdy,
                      input logic rrdy, input logic rsp_en);
    @(negedge clk_i);
    flush_i = fl; flush_addr_i = fa; out_ready_i = rdy; req_ready_i = rrdy;
    rsp_valid_i = rsp_en && (tail != head);
    rsp_data_i  = rsp_valid_i ? dfn(bq[head % 16]) : 32'h0;
    rsp_err_i   = rsp_valid_i ? efn(bq[head % 16]) : 1'b0;
    #1;
    if (last_flush) begin
      chk(!out_valid_o, "R7 empty after flush", {31'b0, out_valid_o}, 0);
      if (!fl) chk(req_valid_o == ((tail - head) < MAX_OUT), "R10 restart",
                   {31'b0, req_valid_o}, {31'b0, (tail - head) < MAX_OUT});
    end
    if (req_valid_o) chk(req_addr_o == exp_req, "R2 request address", req_addr_o, exp_req);
    if (out_valid_o && rdy && !fl) begin
      chk(out_addr_o == exp_addr, "R4/R8 order", out_addr_o, exp_addr);
      chk(out_data_o == dfn(exp_addr), "R4 data", out_data_o, dfn(exp_addr));
      chk(out_err_o == efn(exp_addr), "R5 error tag", {31'b0, out_err_o}, {31'b0, efn(exp_addr)});
      chk(fault_o == efn(exp_addr), "R6 fault on take", {31'b0, fault_o}, {31'b0, efn(exp_addr)});
      if (fault_o) begin
        faults_seen++;
        chk(fault_addr_o == exp_addr, "R6 fault address", fault_addr_o, exp_addr);
      end
      exp_addr += 4;
    end else begin
      chk(!fault_o, fl ? "R9 flush beats consume" : "R5 no early fault", {31'b0, fault_o}, 0);
    end
    if (rsp_valid_i) head++;
    if (req_valid_o && rrdy) begin
      bq[tail % 16] = req_addr_o;
      tail++;
      exp_req += 4;
    end
    chk((tail - head) <= MAX_OUT, "R3 outstanding bound", tail - head, MAX_OUT);
    if (fl) begin
      exp_addr = fa;
      exp_req  = fa;
    end
    last_flush = fl;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    #1;
    chk(!out_valid_o, "R1 reset valid", {31'b0, out_valid_o}, 0);
    chk(!fault_o, "R1 reset fault", {31'b0, fault_o}, 0);
    chk(req_valid_o && req_addr_o == 32'h0, "R1 first request", req_addr_o, 0);
    @(negedge clk_i) rst_ni = 1;

    // stalled consumer: fill and stop
    repeat (20) step(0, 0, 0, 1, 1);
    #1;
    chk(out_valid_o && !req_valid_o && (tail == head), "R3 full stop",
        {30'b0, out_valid_o, req_valid_o}, 32'h2);

    // park an errored word at the head, then redirect it away
    step(1, 32'd12, 0, 1, 1);
    repeat (20) step(0, 0, 0, 1, 1);
    #1;
    chk(out_valid_o && out_err_o && out_addr_o == 32'd12 && !fault_o, "R5 parked error",
        out_addr_o, 32'd12);
    step(1, 32'h100, 1, 1, 1);
    repeat (30) step(0, 0, 1, 1, 1);

    // errored word consumed directly
    step(1, 32'd12, 0, 1, 1);
    repeat (10) step(0, 0, 1, 1, 1);

    // back-to-back flushes with responses in flight
    repeat (3) step(0, 0, 0, 1, 0);
    step(1, 32'h200, 0, 1, 0);
    step(1, 32'h300, 0, 1, 1);
    repeat (30) step(0, 0, 1, 1, ($urandom % 2) == 0);

    for (int i = 0; i < 4000; i++) begin
      logic fl = ($urandom % 32) == 0;
      step(fl, ($urandom % 256) * 4, ($urandom % 10) < 7, ($urandom % 10) < 6,
           ($urandom % 2) == 0);
    end
    repeat (40) step(0, 0, 1, 1, 1);
    chk(faults_seen > 0, "R6 faults observed", faults_seen, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule